// File: doc/BRIEF.md
# Remap Shape Assignment Unit

This unit turns one shape-setup command into a 32-bit shape descriptor and attaches that descriptor to operand slots. There are five slots: three source operands (A, B, C) and two result operands (T, S/EA). The unit holds four shape registers, one 2-bit shape selector for each slot, a 5-bit slot enable mask and a persistence flag. A downstream address generator reads all of these. The descriptor comes in two variants. The indexed variant carries a GPR base and an element-width override. The offset variant carries a 4-bit element offset. In both variants the second dimension is derived from the current maximum vector length.

A command is accepted when the unit is idle. A fixed-length search then finds the second dimension, and the registers are updated in a single cycle that is marked by a one-cycle `done_o` pulse. Which update is applied depends on the command's persistence bit. In bulk mode, all earlier state is wiped and shapes are handed out round-robin to the enabled slots. In refined mode, the mask is read as a slot number plus a shape index, and exactly one register pair is patched.

Top module: `remap_shape_unit`

## Requirements
- R1: After reset all shape registers, selectors, the enable mask and the persistence flag are zero, and `busy_o` and `done_o` are low.
- R2: A command is captured on a rising edge where `cmd_valid_i` is high and `busy_o` is low. `busy_o` is high from the next cycle onward. Exactly 64 rising edges after the capture edge, `done_o` is high for one cycle, and all register outputs already show the new values in that cycle.
- R3: A command presented while `busy_o` is high is ignored, and the result equals that of the command in progress.
- R4: The second dimension d is the smallest integer with d·(dim+1) ≥ maxvl, capped at 63. The value d−1 taken modulo 64 appears as ydim in shape bits [11:6] in y/x order without skip (so maxvl = 0 gives 63).
- R5: Indexed shape (variant 0), with bit 0 as the LSB: bits [5:0] = {0, dim}; [17:12] = {0, gpr}; [20:18] = 110 for x/y order (yx=0) or 111 for y/x order (yx=1); bit 21 = skip; [29:28] = element-width override; [31:30] = 00; all other bits 0.
- R6: ydim in bits [11:6] is 0 for x/y order without skip and 63 for x/y order with skip. It is d−1 for y/x order without skip and 0 for y/x order with skip.
- R7: Offset shape (variant 1): bits [5:0] and [11:6] follow R4 to R6; [20:18] = 000 for x/y order or 010 for y/x order; [27:24] = offset; [29:28] = 01 when skip is set, otherwise 00; all other bits 0.
- R8: Bulk mode (persist=0) clears all four shapes, all selectors and the enable mask, then sets the enable mask to the command mask. Mask bit 4 is slot 0 (A), bit 3 is B, bit 2 is C, bit 1 is T and bit 0 is S/EA. The enabled slots are walked from slot 0 upward and receive shape indices 0, 1, 2, 3, 0. The descriptor is written into each shape register that is handed out.
- R9: Refined mode (persist=1) reads mask[4:2] as the slot number and mask[1:0] as the shape index. It writes the descriptor into that shape register, sets that slot's selector to the index and sets that slot's enable bit. All other state is kept.
- R10: Every command writes its persistence bit to `persist_o`.
- R11: In refined mode, a slot number of 5, 6 or 7 writes only the shape register. Selectors and enable bits stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_variant_i | input | 1 | 0 = indexed shape, 1 = offset shape |
| cmd_mask_i | input | 5 | Slot mask (bulk) or slot/index fields (refined) |
| cmd_dim_i | input | 5 | First dimension minus one |
| cmd_gpr_i | input | 5 | GPR base for indexed shapes |
| cmd_elw_i | input | 2 | Element-width override for indexed shapes |
| cmd_yx_i | input | 1 | Dimension order: 0 = x/y, 1 = y/x |
| cmd_skip_i | input | 1 | Skip first dimension |
| cmd_persist_i | input | 1 | 0 = bulk mode, 1 = refined mode |
| cmd_offset_i | input | 4 | Element offset for offset shapes |
| maxvl_i | input | 7 | Current maximum vector length |
| shapes_o | output | 128 | Shape register n at bits [32n+31:32n] |
| slot_sel_o | output | 10 | Selector of slot k at bits [2k+1:2k], slot 0 = A |
| slot_en_o | output | 5 | Slot enables, bit 4 = A down to bit 0 = S/EA |
| persist_o | output | 1 | Persistence flag of the last command |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every register result is due exactly 64 rising edges after the capture edge, in the same cycle as the `done_o` pulse. The bench drives inputs on falling edges and counts falling edges after the capture edge until `done_o` appears. Both the count and every output are judged at that falling edge. `busy_o` is checked at the first falling edge after capture, and the low `done_o` is checked one falling edge after the pulse. For the ignored-command case, a conflicting command is driven halfway through the search, and the outputs are compared with the first command's expected values once it completes.

// File: rtl/remap_shape_pkg.sv
package remap_shape_pkg;

    localparam int SHAPE_W    = 32;
    localparam int NUM_SHAPES = 4;
    localparam int NUM_SLOTS  = 5;
    localparam int IDX_W      = 2;
    localparam int DIM_W      = 5;
    localparam int MVL_W      = 7;
    localparam int FIELD_W    = 6;

    // descriptor field positions (LSB numbering)
    localparam int POS_XDIM   = 0;
    localparam int POS_YDIM   = 6;
    localparam int POS_GPR    = 12;
    localparam int POS_PERM   = 18;
    localparam int POS_SKIPF  = 21;
    localparam int POS_OFFS   = 24;
    localparam int POS_EXTRA  = 28;
    localparam int POS_MODE   = 30;

    localparam logic [2:0] PERM_IDX_XY = 3'b110;
    localparam logic [2:0] PERM_IDX_YX = 3'b111;
    localparam logic [2:0] PERM_OFS_XY = 3'b000;
    localparam logic [2:0] PERM_OFS_YX = 3'b010;

    typedef struct packed {
        logic               variant;
        logic [NUM_SLOTS-1:0] mask;
        logic [DIM_W-1:0]   dim;
        logic [DIM_W-1:0]   gpr;
        logic [1:0]         elw;
        logic               yx;
        logic               skip;
        logic               persist;
        logic [3:0]         offset;
        logic [MVL_W-1:0]   maxvl;
    } shape_cmd_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SEARCH = 1'b1
    } unit_state_e;

endpackage

// File: rtl/rsu_dim_search.sv
module rsu_dim_search #(
    parameter int DIM_W = 5,
    parameter int MVL_W = 7,
    parameter int MAX_D = 63
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           start_i,
    input  logic [DIM_W-1:0]               dim_i,
    input  logic [MVL_W-1:0]               maxvl_i,
    output logic [$clog2(MAX_D+1)-1:0]     d_o,
    output logic                           fin_o
);

    localparam int D_W    = $clog2(MAX_D + 1);
    localparam int CNT_W  = $clog2(MAX_D + 1);
    localparam int PROD_W = D_W + DIM_W + 2;

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [D_W-1:0]    d;
        logic [PROD_W-1:0] prod;
        logic              fin;
    } search_t;

    search_t s_d, s_q;
    logic [PROD_W-1:0] step_w;
    logic [PROD_W-1:0] limit_w;

    assign step_w  = PROD_W'(dim_i) + PROD_W'(1);
    assign limit_w = PROD_W'(maxvl_i);

    always_comb begin
        s_d     = s_q;
        s_d.fin = 1'b0;
        if (start_i) begin
            s_d.active = 1'b1;
            s_d.cnt    = '0;
            s_d.d      = '0;
            s_d.prod   = '0;
        end else if (s_q.active) begin
            if ((s_q.prod < limit_w) && (s_q.d < D_W'(MAX_D))) begin
                s_d.d    = s_q.d + D_W'(1);
                s_d.prod = s_q.prod + step_w;
            end
            s_d.cnt = s_q.cnt + CNT_W'(1);
            if (s_q.cnt == CNT_W'(MAX_D - 1)) begin
                s_d.active = 1'b0;
                s_d.fin    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign d_o   = s_q.d;
    assign fin_o = s_q.fin;

    // R4
    dim_reached_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.fin |-> ((s_q.d == D_W'(MAX_D)) ||
                     ((PROD_W'(s_q.d) * step_w) >= limit_w)));

    // R4
    dim_minimal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.fin && (s_q.d != '0)) |-> ((PROD_W'(s_q.d - D_W'(1)) * step_w) < limit_w));

    // R2
    fin_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.fin |=> !s_q.fin);

endmodule

// File: rtl/rsu_shape_build.sv
module rsu_shape_build
    import remap_shape_pkg::*;
#(
    parameter int D_W = 6
) (
    input  shape_cmd_t          cmd_i,
    input  logic [D_W-1:0]      d_i,
    output logic [SHAPE_W-1:0]  shape_o
);

    logic [FIELD_W-1:0] ydim;
    logic [D_W-1:0]     d_minus1;

    assign d_minus1 = d_i - D_W'(1);

    always_comb begin
        if (!cmd_i.yx) ydim = cmd_i.skip ? '1 : '0;
        else           ydim = cmd_i.skip ? '0 : FIELD_W'(d_minus1);
    end

    always_comb begin
        shape_o = '0;
        shape_o[POS_XDIM +: FIELD_W] = FIELD_W'(cmd_i.dim);
        shape_o[POS_YDIM +: FIELD_W] = ydim;
        shape_o[POS_MODE +: 2]       = 2'b00;
        if (!cmd_i.variant) begin
            shape_o[POS_PERM +: 3]       = cmd_i.yx ? PERM_IDX_YX : PERM_IDX_XY;
            shape_o[POS_GPR +: FIELD_W]  = FIELD_W'(cmd_i.gpr);
            shape_o[POS_SKIPF]           = cmd_i.skip;
            shape_o[POS_EXTRA +: 2]      = cmd_i.elw;
        end else begin
            shape_o[POS_PERM +: 3]       = cmd_i.yx ? PERM_OFS_YX : PERM_OFS_XY;
            shape_o[POS_OFFS +: 4]       = cmd_i.offset;
            shape_o[POS_EXTRA +: 2]      = cmd_i.skip ? 2'b01 : 2'b00;
        end
    end

endmodule

// File: rtl/rsu_slot_alloc.sv
module rsu_slot_alloc #(
    parameter int SHAPE_W    = 32,
    parameter int NUM_SHAPES = 4,
    parameter int NUM_SLOTS  = 5,
    parameter int IDX_W      = 2
) (
    input  logic [NUM_SHAPES-1:0][SHAPE_W-1:0] shapes_i,
    input  logic [NUM_SLOTS-1:0][IDX_W-1:0]    sel_i,
    input  logic [NUM_SLOTS-1:0]               en_i,
    input  logic [SHAPE_W-1:0]                 new_shape_i,
    input  logic [NUM_SLOTS-1:0]               mask_i,
    input  logic                               refined_i,
    output logic [NUM_SHAPES-1:0][SHAPE_W-1:0] shapes_o,
    output logic [NUM_SLOTS-1:0][IDX_W-1:0]    sel_o,
    output logic [NUM_SLOTS-1:0]               en_o
);

    localparam int SLOT_W = NUM_SLOTS - IDX_W;

    logic [SLOT_W-1:0] r_slot;
    logic [IDX_W-1:0]  r_idx;

    assign r_slot = mask_i[NUM_SLOTS-1 -: SLOT_W];
    assign r_idx  = mask_i[IDX_W-1:0];

    always_comb begin
        logic [IDX_W-1:0] next_idx;
        next_idx = '0;
        if (refined_i) begin
            shapes_o = shapes_i;
            sel_o    = sel_i;
            en_o     = en_i;
            for (int h = 0; h < NUM_SHAPES; h++) begin
                if (r_idx == IDX_W'(h)) shapes_o[h] = new_shape_i;
            end
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (r_slot == SLOT_W'(s)) begin
                    sel_o[s]               = r_idx;
                    en_o[NUM_SLOTS-1-s]    = 1'b1;
                end
            end
        end else begin
            shapes_o = '0;
            sel_o    = '0;
            en_o     = mask_i;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (mask_i[NUM_SLOTS-1-s]) begin
                    for (int h = 0; h < NUM_SHAPES; h++) begin
                        if (next_idx == IDX_W'(h)) shapes_o[h] = new_shape_i;
                    end
                    sel_o[s] = next_idx;
                    if (next_idx == IDX_W'(NUM_SHAPES - 1)) next_idx = '0;
                    else                                     next_idx = next_idx + IDX_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/remap_shape_unit.sv
module remap_shape_unit
    import remap_shape_pkg::*;
#(
    parameter int MAX_D = 63
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            cmd_valid_i,
    input  logic                            cmd_variant_i,
    input  logic [NUM_SLOTS-1:0]            cmd_mask_i,
    input  logic [DIM_W-1:0]                cmd_dim_i,
    input  logic [DIM_W-1:0]                cmd_gpr_i,
    input  logic [1:0]                      cmd_elw_i,
    input  logic                            cmd_yx_i,
    input  logic                            cmd_skip_i,
    input  logic                            cmd_persist_i,
    input  logic [3:0]                      cmd_offset_i,
    input  logic [MVL_W-1:0]                maxvl_i,
    output logic [NUM_SHAPES*SHAPE_W-1:0]   shapes_o,
    output logic [NUM_SLOTS*IDX_W-1:0]      slot_sel_o,
    output logic [NUM_SLOTS-1:0]            slot_en_o,
    output logic                            persist_o,
    output logic                            busy_o,
    output logic                            done_o
);

    localparam int D_W = $clog2(MAX_D + 1);

    typedef struct packed {
        unit_state_e                           state;
        shape_cmd_t                            cmd;
        logic [NUM_SHAPES-1:0][SHAPE_W-1:0]    shapes;
        logic [NUM_SLOTS-1:0][IDX_W-1:0]       sel;
        logic [NUM_SLOTS-1:0]                  en;
        logic                                  persist;
        logic                                  done;
    } unit_regs_t;

    unit_regs_t r_d, r_q;

    logic                                 start_w;
    logic [D_W-1:0]                       d_w;
    logic                                 fin_w;
    logic [SHAPE_W-1:0]                   new_shape_w;
    logic [NUM_SHAPES-1:0][SHAPE_W-1:0]   shapes_n;
    logic [NUM_SLOTS-1:0][IDX_W-1:0]      sel_n;
    logic [NUM_SLOTS-1:0]                 en_n;
    shape_cmd_t                           in_cmd;

    assign start_w = cmd_valid_i && (r_q.state == ST_IDLE);

    assign in_cmd = '{variant: cmd_variant_i, mask: cmd_mask_i, dim: cmd_dim_i,
                      gpr: cmd_gpr_i, elw: cmd_elw_i, yx: cmd_yx_i,
                      skip: cmd_skip_i, persist: cmd_persist_i,
                      offset: cmd_offset_i, maxvl: maxvl_i};

    rsu_dim_search #(
        .DIM_W (DIM_W),
        .MVL_W (MVL_W),
        .MAX_D (MAX_D)
    ) u_search (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_w),
        .dim_i   (r_q.cmd.dim),
        .maxvl_i (r_q.cmd.maxvl),
        .d_o     (d_w),
        .fin_o   (fin_w)
    );

    rsu_shape_build #(
        .D_W (D_W)
    ) u_build (
        .cmd_i   (r_q.cmd),
        .d_i     (d_w),
        .shape_o (new_shape_w)
    );

    rsu_slot_alloc #(
        .SHAPE_W    (SHAPE_W),
        .NUM_SHAPES (NUM_SHAPES),
        .NUM_SLOTS  (NUM_SLOTS),
        .IDX_W      (IDX_W)
    ) u_alloc (
        .shapes_i    (r_q.shapes),
        .sel_i       (r_q.sel),
        .en_i        (r_q.en),
        .new_shape_i (new_shape_w),
        .mask_i      (r_q.cmd.mask),
        .refined_i   (r_q.cmd.persist),
        .shapes_o    (shapes_n),
        .sel_o       (sel_n),
        .en_o        (en_n)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid_i) begin
                    r_d.cmd   = in_cmd;
                    r_d.state = ST_SEARCH;
                end
            end
            ST_SEARCH: begin
                if (fin_w) begin
                    r_d.shapes  = shapes_n;
                    r_d.sel     = sel_n;
                    r_d.en      = en_n;
                    r_d.persist = r_q.cmd.persist;
                    r_d.done    = 1'b1;
                    r_d.state   = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign shapes_o   = r_q.shapes;
    assign slot_sel_o = r_q.sel;
    assign slot_en_o  = r_q.en;
    assign persist_o  = r_q.persist;
    assign busy_o     = (r_q.state != ST_IDLE);
    assign done_o     = r_q.done;

    // R2
    done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(busy_o));

    // R2
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R3
    state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(slot_en_o) && $stable(slot_sel_o) && $stable(persist_o)));

    // R10
    persist_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (persist_o == r_q.cmd.persist));

    // R8
    bulk_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !persist_o) |-> (slot_en_o == r_q.cmd.mask));

    // R8
    bulk_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !persist_o && r_q.cmd.mask[NUM_SLOTS-1]) |-> (slot_sel_o[IDX_W-1:0] == '0));

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel_chk
        // R8
        idle_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (done_o && !persist_o && !r_q.cmd.mask[NUM_SLOTS-1-g])
                |-> (slot_sel_o[g*IDX_W +: IDX_W] == '0));
    end

endmodule

// File: tb/remap_shape_unit_tb.sv
module remap_shape_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_variant = 1'b0;
    logic [4:0]   cmd_mask = '0;
    logic [4:0]   cmd_dim = '0;
    logic [4:0]   cmd_gpr = '0;
    logic [1:0]   cmd_elw = '0;
    logic         cmd_yx = 1'b0;
    logic         cmd_skip = 1'b0;
    logic         cmd_persist = 1'b0;
    logic [3:0]   cmd_offset = '0;
    logic [6:0]   maxvl = '0;
    logic [127:0] shapes;
    logic [9:0]   slot_sel;
    logic [4:0]   slot_en;
    logic         persist;
    logic         busy;
    logic         done;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_shape [4];
    logic [1:0]  m_sel   [5];
    logic [4:0]  m_en;
    logic        m_persist;

    always #(CLK_PERIOD/2) clk = ~clk;

    remap_shape_unit u_dut (
        .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid),
        .cmd_variant_i(cmd_variant), .cmd_mask_i(cmd_mask), .cmd_dim_i(cmd_dim),
        .cmd_gpr_i(cmd_gpr), .cmd_elw_i(cmd_elw), .cmd_yx_i(cmd_yx),
        .cmd_skip_i(cmd_skip), .cmd_persist_i(cmd_persist),
        .cmd_offset_i(cmd_offset), .maxvl_i(maxvl), .shapes_o(shapes),
        .slot_sel_o(slot_sel), .slot_en_o(slot_en), .persist_o(persist),
        .busy_o(busy), .done_o(done)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_shape(input logic v, input logic [4:0] dim,
        input logic [4:0] gpr, input logic [1:0] elw, input logic yx, input logic sk,
        input logic [3:0] ofs, input logic [6:0] mvl);
        logic [31:0] s;
        int d;
        int ydim;
        d = (int'(mvl) + int'(dim)) / (int'(dim) + 1);
        if (d > 63) d = 63;
        if (!yx) ydim = sk ? 63 : 0;
        else     ydim = sk ? 0 : ((d + 63) % 64);
        s = 32'(dim) | (32'(ydim) << 6);
        if (!v) begin
            s = s | (32'(gpr) << 12) | (32'(yx ? 7 : 6) << 18) | (32'(sk) << 21) | (32'(elw) << 28);
        end else begin
            s = s | (32'(yx ? 2 : 0) << 18) | (32'(ofs) << 24) | (32'(sk ? 1 : 0) << 28);
        end
        return s;
    endfunction

    task automatic model_apply(input logic [31:0] s);
        if (!cmd_persist) begin
            int idx;
            idx = 0;
            for (int h = 0; h < 4; h++) m_shape[h] = '0;
            for (int k = 0; k < 5; k++) m_sel[k] = '0;
            m_en = cmd_mask;
            for (int k = 0; k < 5; k++) begin
                if (cmd_mask[4-k]) begin
                    m_shape[idx] = s;
                    m_sel[k] = 2'(idx);
                    idx = (idx + 1) % 4;
                end
            end
        end else begin
            int slot;
            slot = int'(cmd_mask[4:2]);
            m_shape[cmd_mask[1:0]] = s;
            if (slot < 5) begin
                m_sel[slot] = cmd_mask[1:0];
                m_en[4-slot] = 1'b1;
            end
        end
        m_persist = cmd_persist;
    endtask

    function automatic logic [127:0] m_shapes_flat();
        return {m_shape[3], m_shape[2], m_shape[1], m_shape[0]};
    endfunction

    function automatic logic [9:0] m_sel_flat();
        return {m_sel[4], m_sel[3], m_sel[2], m_sel[1], m_sel[0]};
    endfunction

    // issue a command at a falling edge, wait for done and check everything
    task automatic run_cmd(input string tag, input logic v, input logic [4:0] mask,
        input logic [4:0] dim, input logic [4:0] gpr, input logic [1:0] elw,
        input logic yx, input logic sk, input logic pe, input logic [3:0] ofs,
        input logic [6:0] mvl, input bit interfere);
        logic [31:0] s;
        int n;
        cmd_variant = v; cmd_mask = mask; cmd_dim = dim; cmd_gpr = gpr;
        cmd_elw = elw; cmd_yx = yx; cmd_skip = sk; cmd_persist = pe;
        cmd_offset = ofs; maxvl = mvl; cmd_valid = 1'b1;
        s = exp_shape(v, dim, gpr, elw, yx, sk, ofs, mvl);
        model_apply(s);
        @(negedge clk);
        cmd_valid = 1'b0;
        // R2 busy after capture
        chk("R2 busy", 128'(busy), 128'(1));
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
            if (interfere && n == 20) begin
                // R3 conflicting command while busy
                cmd_valid = 1'b1; cmd_mask = ~mask; cmd_dim = ~dim;
                cmd_persist = ~pe; cmd_variant = ~v; maxvl = ~mvl;
            end
            if (interfere && n == 21) cmd_valid = 1'b0;
        end
        chk("R2 latency", 128'(n), 128'(LAT));
        chk({tag, " shapes"}, shapes, m_shapes_flat());
        chk({tag, " sel"}, 128'(slot_sel), 128'(m_sel_flat()));
        chk({tag, " en"}, 128'(slot_en), 128'(m_en));
        chk("R10 persist", 128'(persist), 128'(m_persist));
        @(negedge clk);
        chk("R2 done pulse", 128'(done), 128'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int h = 0; h < 4; h++) m_shape[h] = '0;
        for (int k = 0; k < 5; k++) m_sel[k] = '0;
        m_en = '0;
        m_persist = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 shapes", shapes, '0);
        chk("R1 sel", 128'(slot_sel), '0);
        chk("R1 en", 128'(slot_en), '0);
        chk("R1 flags", 128'({persist, busy, done}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", 128'({busy, done}), '0);

        // R4 sweep of the second dimension, y/x order, no skip
        for (int dm = 0; dm < 32; dm++) begin
            for (int mv = 0; mv < 128; mv += 9) begin
                run_cmd("R4", 1'b0, 5'b10000, 5'(dm), 5'd3, 2'd1, 1'b1, 1'b0, 1'b0,
                        4'd0, 7'(mv), 1'b0);
            end
            run_cmd("R4", 1'b0, 5'b10000, 5'(dm), 5'd3, 2'd1, 1'b1, 1'b0, 1'b0,
                    4'd0, 7'd127, 1'b0);
        end

        // R5 R6 R7 descriptor field sweep
        for (int v = 0; v < 2; v++) begin
            for (int c = 0; c < 16; c++) begin
                run_cmd(v == 0 ? "R5 R6" : "R7 R6", 1'(v), 5'b01000, 5'(c * 2 + 1),
                        5'(31 - c), 2'(c), 1'(c >> 2), 1'(c >> 3), 1'b0,
                        4'(15 - c), 7'(c * 7 + 5), 1'b0);
            end
        end

        // R8 bulk mode over every mask
        for (int mk = 0; mk < 32; mk++) begin
            run_cmd("R8", 1'(mk), 5'(mk), 5'(mk), 5'(mk + 1), 2'(mk), 1'(mk >> 1),
                    1'(mk >> 2), 1'b0, 4'(mk), 7'(mk * 3), 1'b0);
        end

        // R9 R11 refined mode over every mask
        run_cmd("R8", 1'b0, 5'b11111, 5'd7, 5'd9, 2'd2, 1'b0, 1'b0, 1'b0,
                4'd0, 7'd40, 1'b0);
        for (int mk = 0; mk < 32; mk++) begin
            run_cmd(mk >= 20 ? "R11" : "R9", 1'(mk >> 1), 5'(mk), 5'(31 - mk),
                    5'(mk), 2'(mk >> 1), 1'(mk), 1'(mk >> 3), 1'b1, 4'(mk + 3),
                    7'(mk * 4), 1'b0);
        end

        // R3 command during search is ignored
        run_cmd("R3", 1'b0, 5'b10101, 5'd4, 5'd6, 2'd3, 1'b1, 1'b0, 1'b0,
                4'd2, 7'd50, 1'b1);
        run_cmd("R3", 1'b1, 5'b01110, 5'd2, 5'd1, 2'd0, 1'b0, 1'b1, 1'b1,
                4'd9, 7'd17, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule